// File: doc/BRIEF.md
# NAND Flash Cycle Sequencer

The sequencer runs one complete access to a NAND flash device as a programmed series of phases. A host presents a descriptor and pulses a start request. The descriptor gives the first and second command bytes and how many are sent, the address bytes and how many are sent, whether a data byte moves and in which direction, and two strobe high-time codes. The block then drives chip enable, the command and address latch enables, the write and read strobes and the shared data bus. Every phase has a strobe low time of one clock, followed by a programmable high time.

The flash ready/busy line passes through a two-flop synchronizer. A new access is accepted only while the synchronized line shows ready. An access already running is not affected by busy, and it reports completion without waiting for the device. This lets the host finish its transaction while the flash is still programming or erasing. The next access is then held off until ready returns. The same synchronized value is shown to the host as a device-busy status.

Top module: `nand_cycle_seq`

## Requirements
- R1: While reset is held and while idle, chip enable, write strobe and read strobe are high, the two latch enables are low, the bus enable is low, the bus output is zero and done is low. Right after reset the status shows busy until two clock edges have sampled a ready line.
- R2: A start request is accepted only when `ready_o` is high, which means idle with the synchronized line at ready. A request at any other time, including during a running access, is ignored. Chip enable is low from the cycle after acceptance until the last phase ends. The descriptor is captured at acceptance, so later changes to it have no effect on the running access.
- R3: Phases run in this order: first command, then the address bytes, then the optional data byte, then the second command. A command count of 0 sends no command and 1 sends only the first. A count of 2 or 3 sends both.
- R4: An address count of 0 to 4 sends that many address bytes, lowest byte first: byte k is `addr_i[8k+7:8k]`. A count above 4 sends 4.
- R5: Each phase pulls exactly one strobe low for one clock, then holds it high for (code+1) clocks. The read strobe and `re_high_i` are used for a data read. The write strobe and `we_high_i` are used for commands, addresses and a data write. The two strobes are never low together.
- R6: The command latch enable is high exactly during command phases, and the address latch enable exactly during address phases. During command, address and write-data phases the bus enable is high and `io_o` carries that phase's byte. During a read phase and while idle the bus is not driven and `io_o` is zero.
- R7: On a read, `io_i` is captured at the clock edge that ends the read-strobe low cycle. `rdata_o` holds that value until the next read.
- R8: `done_o` is a one-cycle pulse in the first idle cycle after the last phase. A descriptor with no phases gives that pulse in the cycle after acceptance, and chip enable stays high.
- R9: `busy_o` is the inverse of `rb_i` (1 = ready) after two synchronizing flops. It changes after the second clock edge that samples a new value.
- R10: A busy indication that arrives during an access neither stalls nor changes it. `done_o` does not wait for ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request for one access |
| cmd_cnt_i | input | 2 | Number of command bytes (0..2; 3 acts as 2) |
| addr_cnt_i | input | 3 | Number of address bytes (0..4; larger acts as 4) |
| data_en_i | input | 1 | Include a data phase |
| data_wr_i | input | 1 | Data phase direction: 1 write, 0 read |
| cmd0_i | input | 8 | First command byte |
| cmd1_i | input | 8 | Second command byte |
| addr_i | input | 32 | Address bytes, byte 0 sent first |
| wdata_i | input | 8 | Write data byte |
| we_high_i | input | 2 | Write strobe high time code (clocks = code+1) |
| re_high_i | input | 2 | Read strobe high time code (clocks = code+1) |
| rb_i | input | 1 | Flash ready/busy, 1 = ready (asynchronous) |
| io_i | input | 8 | Data bus from flash |
| ready_o | output | 1 | Block can accept a start request |
| done_o | output | 1 | One-cycle pulse at end of access |
| busy_o | output | 1 | Device busy status (synchronized) |
| rdata_o | output | 8 | Last byte read |
| ce_no | output | 1 | Chip enable, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |
| io_o | output | 8 | Data bus to flash |
| io_oe_o | output | 1 | Bus output enable |

## Verification
On every cycle the assertions check the properties that hold at any instant. The two latch enables are never high together and the two strobes are never low together. A low strobe goes high on the next clock. The idle pins stay quiet while chip enable is high. An idle cycle with busy showing stays idle, and chip enable rises only together with the done pulse. The phase order, the byte on the bus in each phase, the high-time counts per direction, the read capture edge, the clamping of oversized counts and the two-edge synchronizer latency can only be shown by the bench's scenarios. The bench compares every clock against a behavioural model built from the descriptor.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CMD0 = 3'd1,
    PH_ADDR = 3'd2,
    PH_DATA = 3'd3,
    PH_CMD1 = 3'd4
  } phase_e;

  // Next phase after cur has fully finished (address: after its last byte).
  function automatic phase_e after_phase(phase_e cur, logic has_c0, logic has_addr,
                                         logic has_data, logic has_c1);
    if (cur == PH_IDLE && has_c0) return PH_CMD0;
    if ((cur == PH_IDLE || cur == PH_CMD0) && has_addr) return PH_ADDR;
    if (cur != PH_DATA && cur != PH_CMD1 && has_data) return PH_DATA;
    if (cur != PH_CMD1 && has_c1) return PH_CMD1;
    return PH_IDLE;
  endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rb_i,
  output logic rb_o
);
  logic [STAGES-1:0] sync_q;

  // Resets to busy so no access starts before the line is sampled.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], rb_i};
  end

  assign rb_o = sync_q[STAGES-1];
endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer #(
  parameter int HIGH_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [HIGH_W-1:0] high_i,
  output logic              low_o,
  output logic              last_o
);
  logic              low_q;
  logic [HIGH_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_i) begin
      if (low_q) begin
        low_q <= 1'b0;
        cnt_q <= high_i;
      end else if (cnt_q == '0) begin
        low_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign low_o  = low_q;
  assign last_o = run_i && !low_q && (cnt_q == '0);

  // R5
  low_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && low_q) |=> !low_o);
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_BYTES  = 4,
  parameter int HIGH_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ACNT_W      = $clog2(ADDR_BYTES + 1),
  parameter int ADDR_W      = DATA_W * ADDR_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        cmd_cnt_i,
  input  logic [ACNT_W-1:0] addr_cnt_i,
  input  logic              data_en_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] cmd0_i,
  input  logic [DATA_W-1:0] cmd1_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [HIGH_W-1:0] we_high_i,
  input  logic [HIGH_W-1:0] re_high_i,
  input  logic              rb_i,
  input  logic [DATA_W-1:0] io_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ce_no,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [DATA_W-1:0] io_o,
  output logic              io_oe_o
);
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  phase_e ph_q, first_ph, next_ph;
  logic   rb_s, accept, strobe_low, phase_last, last_addr, rd_phase;
  logic   c0_q, c1_q, de_q, rd_q, done_q;
  logic [ACNT_W-1:0] n_addr_in, n_addr_q, addr_idx_q;
  logic [DATA_W-1:0] cmd0_q, cmd1_q, wdata_q, rdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic [HIGH_W-1:0] weh_q, reh_q, high_sel;
  logic [DATA_W-1:0] addr_bytes [ADDR_BYTES];

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .rb_i(rb_i), .rb_o(rb_s)
  );

  assign rd_phase = (ph_q == PH_DATA) && rd_q;
  assign high_sel = rd_phase ? reh_q : weh_q;

  nand_strobe_timer #(.HIGH_W(HIGH_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ph_q != PH_IDLE),
    .high_i(high_sel), .low_o(strobe_low), .last_o(phase_last)
  );

  assign ready_o   = (ph_q == PH_IDLE) && rb_s;
  assign accept    = start_i && ready_o;
  assign n_addr_in = (addr_cnt_i > ACNT_W'(ADDR_BYTES)) ? ACNT_W'(ADDR_BYTES) : addr_cnt_i;
  assign first_ph  = after_phase(PH_IDLE, cmd_cnt_i != 2'd0, n_addr_in != '0,
                                 data_en_i, cmd_cnt_i[1]);
  assign next_ph   = after_phase(ph_q, c0_q, n_addr_q != '0, de_q, c1_q);
  assign last_addr = (addr_idx_q == n_addr_q - ACNT_W'(1));

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
    assign addr_bytes[g] = addr_q[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      addr_idx_q <= '0;
      n_addr_q   <= '0;
      c0_q       <= 1'b0;
      c1_q       <= 1'b0;
      de_q       <= 1'b0;
      rd_q       <= 1'b0;
      cmd0_q     <= '0;
      cmd1_q     <= '0;
      wdata_q    <= '0;
      addr_q     <= '0;
      weh_q      <= '0;
      reh_q      <= '0;
      done_q     <= 1'b0;
      rdata_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        ph_q       <= first_ph;
        addr_idx_q <= '0;
        n_addr_q   <= n_addr_in;
        c0_q       <= cmd_cnt_i != 2'd0;
        c1_q       <= cmd_cnt_i[1];
        de_q       <= data_en_i;
        rd_q       <= !data_wr_i;
        cmd0_q     <= cmd0_i;
        cmd1_q     <= cmd1_i;
        wdata_q    <= wdata_i;
        addr_q     <= addr_i;
        weh_q      <= we_high_i;
        reh_q      <= re_high_i;
        done_q     <= (first_ph == PH_IDLE);
      end else if (phase_last) begin
        if (ph_q == PH_ADDR && !last_addr) begin
          addr_idx_q <= addr_idx_q + 1'b1;
        end else begin
          ph_q       <= next_ph;
          addr_idx_q <= '0;
          done_q     <= (next_ph == PH_IDLE);
        end
      end
      if (rd_phase && strobe_low) rdata_q <= io_i;
    end
  end

  always_comb begin
    io_o = '0;
    unique case (ph_q)
      PH_CMD0: io_o = cmd0_q;
      PH_CMD1: io_o = cmd1_q;
      PH_ADDR: io_o = addr_bytes[addr_idx_q[IDX_W-1:0]];
      PH_DATA: io_o = rd_q ? '0 : wdata_q;
      default: io_o = '0;
    endcase
  end

  assign ce_no   = (ph_q == PH_IDLE);
  assign cle_o   = (ph_q == PH_CMD0) || (ph_q == PH_CMD1);
  assign ale_o   = (ph_q == PH_ADDR);
  assign we_no   = !(strobe_low && (ph_q != PH_IDLE) && !rd_phase);
  assign re_no   = !(strobe_low && rd_phase);
  assign io_oe_o = (ph_q != PH_IDLE) && !rd_phase;
  assign done_o  = done_q;
  assign busy_o  = !rb_s;
  assign rdata_o = rdata_q;

  // R6
  latch_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));
  // R5
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |=> we_no);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_no |-> (!cle_o && !ale_o && we_no && re_no && !io_oe_o));
  // R2
  holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_no && busy_o) |=> ce_no);
  // R8
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_no) |-> done_o);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ce_no);
endmodule

// File: tb/nand_cycle_seq_tb.sv
module nand_cycle_seq_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, data_en_i = 1'b0, data_wr_i = 1'b0, rb_i = 1'b0;
  logic [1:0] cmd_cnt_i = '0, we_high_i = '0, re_high_i = '0;
  logic [2:0] addr_cnt_i = '0;
  logic [7:0] cmd0_i = '0, cmd1_i = '0, wdata_i = '0, io_i = 8'hEE;
  logic [31:0] addr_i = '0;
  logic ready_o, done_o, busy_o, ce_no, cle_o, ale_o, we_no, re_no, io_oe_o;
  logic [7:0] rdata_o, io_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [14:0] expq[$];

  always #5 clk = ~clk;

  nand_cycle_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cmd_cnt_i(cmd_cnt_i),
    .addr_cnt_i(addr_cnt_i), .data_en_i(data_en_i), .data_wr_i(data_wr_i),
    .cmd0_i(cmd0_i), .cmd1_i(cmd1_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_high_i(we_high_i), .re_high_i(re_high_i), .rb_i(rb_i), .io_i(io_i),
    .ready_o(ready_o), .done_o(done_o), .busy_o(busy_o), .rdata_o(rdata_o),
    .ce_no(ce_no), .cle_o(cle_o), .ale_o(ale_o), .we_no(we_no), .re_no(re_no),
    .io_o(io_o), .io_oe_o(io_oe_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [14:0] pins();
    return {ce_no, cle_o, ale_o, we_no, re_no, io_oe_o, io_o, done_o};
  endfunction

  // one phase: low clock then (code+1) high clocks
  task automatic push_phase(input bit cle, input bit ale, input bit rd, input logic [7:0] b, input int code);
    expq.push_back({1'b0, cle, ale, rd, !rd, !rd, rd ? 8'h00 : b, 1'b0});
    for (int i = 0; i <= code; i++)
      expq.push_back({1'b0, cle, ale, 1'b1, 1'b1, !rd, rd ? 8'h00 : b, 1'b0});
  endtask

  task automatic run(input int nc, input int na, input bit de, input bit dw,
                     input logic [7:0] c0, input logic [7:0] c1, input logic [31:0] a,
                     input logic [7:0] wd, input int reh, input int weh, input logic [7:0] rdv,
                     input bit poke, input bit busy_mid, input string tag);
    int ncl = (nc > 2) ? 2 : nc;
    int nal = (na > 4) ? 4 : na;
    cmd_cnt_i = 2'(nc); addr_cnt_i = 3'(na); data_en_i = de; data_wr_i = dw;
    cmd0_i = c0; cmd1_i = c1; addr_i = a; wdata_i = wd;
    re_high_i = 2'(reh); we_high_i = 2'(weh); start_i = 1'b1;
    expq.delete();
    if (ncl >= 1) push_phase(1, 0, 0, c0, weh);
    for (int k = 0; k < nal; k++) push_phase(0, 1, 0, a[8*k +: 8], weh);
    if (de) push_phase(0, 0, !dw, wd, dw ? weh : reh);
    if (ncl == 2) push_phase(1, 0, 0, c1, weh);
    expq.push_back({6'b100110, 8'h00, 1'b1});
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; expq.size() > 0; k++) begin
      logic [14:0] e;
      e = expq.pop_front();
      chk(pins() === e, tag, 32'(pins()), 32'(e));
      io_i = (e[10] == 1'b0) ? rdv : 8'hEE;
      if (poke && k == 1) begin start_i = 1'b1; cmd0_i = ~c0; addr_i = ~a; end
      else start_i = 1'b0;
      if (busy_mid && k == 2) rb_i = 1'b0;
      @(negedge clk);
    end
    // R8 done is a single pulse
    chk(pins() === {6'b100110, 8'h00, 1'b0}, "R8 idle after done", 32'(pins()), 32'h4C00);
  endtask

  task automatic wait_ready();
    int g = 0;
    while (!ready_o && g < 20) begin @(negedge clk); g++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(pins() === {6'b100110, 8'h00, 1'b0}, "R1 reset pins", 32'(pins()), 32'h4C00);
    chk(busy_o === 1'b1 && ready_o === 1'b0, "R1 reset busy", {busy_o, ready_o}, 2'b10);
    rst_ni = 1'b1; rb_i = 1'b1;
    @(negedge clk);
    chk(busy_o === 1'b1, "R9 one edge", busy_o, 1);
    @(negedge clk);
    chk(busy_o === 1'b0 && ready_o === 1'b1, "R9 two edges", {busy_o, ready_o}, 2'b01);

    // R3 R5 R6 R7: cmd, 3 addr, read
    run(1, 3, 1, 0, 8'h00, 8'h30, 32'h00C3B2A1, 8'h00, 2, 0, 8'h5C, 0, 0, "R3 R5 R6 read");
    chk(rdata_o === 8'h5C, "R7 read capture", rdata_o, 8'h5C);
    // program shape with both commands, 4 addr, write; descriptor poke mid-run (R2)
    run(2, 4, 1, 1, 8'h80, 8'h10, 32'h44332211, 8'hA7, 0, 3, 8'h00, 1, 0, "R2 R3 R4 write");
    // command only
    run(1, 0, 0, 0, 8'hFF, 8'h00, 32'h0, 8'h00, 0, 1, 8'h00, 0, 0, "R3 cmd only");
    // R4 clamp counts: cmd 3 -> 2, addr 7 -> 4
    run(3, 7, 0, 0, 8'h60, 8'hD0, 32'h87654321, 8'h00, 0, 0, 8'h00, 0, 0, "R4 clamp");
    // R8 empty descriptor
    run(0, 0, 0, 0, 8'h00, 8'h00, 32'h0, 8'h00, 0, 0, 8'h00, 0, 0, "R8 empty");
    // R5 R7 data-only read, longest read high time
    run(0, 0, 1, 0, 8'h00, 8'h00, 32'h0, 8'h00, 3, 0, 8'h96, 0, 0, "R5 read only");
    chk(rdata_o === 8'h96, "R7 read capture 2", rdata_o, 8'h96);

    // R9 R2 busy holds off a start
    rb_i = 1'b0;
    @(negedge clk);
    chk(busy_o === 1'b0, "R9 busy one edge", busy_o, 0);
    @(negedge clk);
    chk(busy_o === 1'b1 && ready_o === 1'b0, "R9 busy two edges", {busy_o, ready_o}, 2'b10);
    cmd_cnt_i = 2'd1; start_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(ce_no === 1'b1 && done_o === 1'b0, "R2 start ignored while busy", {ce_no, done_o}, 2'b10);
    end
    start_i = 1'b0; rb_i = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(ready_o === 1'b1, "R9 ready back", ready_o, 1);

    // R10 busy during access does not stall; done without ready
    run(2, 2, 1, 1, 8'h80, 8'h10, 32'h0000BEEF, 8'h3C, 0, 1, 8'h00, 0, 1, "R10 busy mid");
    chk(busy_o === 1'b1 && ready_o === 1'b0, "R10 held after done", {busy_o, ready_o}, 2'b10);
    rb_i = 1'b1;
    wait_ready();
    chk(ready_o === 1'b1, "R10 ready restored", ready_o, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule